// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

One 16-bit timer channel that counts a slow reference tick divided by a selectable power of two. It has two comparators. When the count steps onto a compare value and that comparator's event mode is armed, a sticky flag is set. The flag, gated by an external enable, drives that comparator's interrupt line. A plain strobe-based register port lets software read and write the compare values, the counter and a combined setup/status word.

Software uses the channel as a clock-event source in two ways. For one-shot or periodic ticks, it loads a compare delta, clears the counter and sets the run bit. To stop the channel and acknowledge both comparators, it writes the setup word once with the run bit clear and both flag bits set. The scale and mode fields lock after the first setup write, which also marks the channel as claimed.

Top module: `evt_timer`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the following are zero: both compare registers, the counter, the setup word (scale, modes, run, flags and claim bit) and `irq_o`.
- R2: The register port decodes `addr_i` as 0 = compare 1, 1 = compare 2, 2 = counter, 3 = setup word. A write takes effect on the clock edge where `wr_en_i` is high. `rdata_o` shows the addressed register combinationally.
- R3: The counter advances only while the run bit (setup bit 11) is set. A counter write loads `wdata_i` and takes priority over an advance in the same cycle. While the run bit is clear, the counter holds.
- R4: The counter advances once per 2^scale reference ticks (`ref_tick_i` high for one cycle). Scale is setup bits [3:0], and values above 8 act as 8. The divider phase is held at zero while stopped, so the first advance after a start comes on the 2^scale-th reference tick.
- R5: The first setup write sets the claim bit (setup bit 15). It also loads scale [3:0], the comparator 1 mode [7:6] and the comparator 2 mode [9:8]. Later setup writes leave those fields unchanged and update only the run bit and the flag clears.
- R6: A comparator's flag (setup bit 13 for comparator 1, bit 14 for comparator 2) is set when the counter advances onto that comparator's compare value and its mode field equals 3. Any other mode value sets no flag, and a counter write that lands on the compare value sets no flag.
- R7: After a match the counter keeps running and wraps from 0xFFFF to 0x0000, matching again only when it next steps onto the compare value.
- R8: A setup write with bit 13 or bit 14 set clears that flag, and the clear wins over a match in the same cycle. A single write with the run bit clear and both flag bits set stops the counter and clears both flags.
- R9: `irq_o[n]` is high exactly while the flag of comparator n+1 is set and `irq_en_i[n]` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Single-cycle reference tick to be prescaled |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| irq_en_i | input | 2 | Per-comparator interrupt enable |
| irq_o | output | 2 | Per-comparator interrupt request |

## Verification
A continuous reference tick at scale 0 checks the match timing cycle by cycle. Scale 2 and an out-of-range scale of 9 show whether the divider period and its restart phase are right and whether large scales are clamped. A count started just below 0xFFFF with a small compare value separates wrap-around matching from a single match. A random phase with sparse reference ticks, random register writes and random enables gives overlapping counter loads, flag clears and matches against the bench's behavioural model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CMP1  = 2'd0,
    ADDR_CMP2  = 2'd1,
    ADDR_CNT   = 2'd2,
    ADDR_SETUP = 2'd3
  } reg_addr_e;

  localparam int N_CMP     = 2;
  localparam int SCALE_LSB = 0;
  localparam int MODE_LSB  = 6;   // comparator n mode at MODE_LSB + 2n
  localparam int RUN_BIT   = 11;
  localparam int FLAG_LSB  = 13;  // comparator n flag at FLAG_LSB + n
  localparam int CLAIM_BIT = 15;
  localparam logic [1:0] EVT_ON = 2'b11;
endpackage

// File: rtl/evt_timer_prescale.sv
module evt_timer_prescale #(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               ref_tick_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               step_o
);
  localparam int PRE_W = (MAX_SCALE < 1) ? 1 : MAX_SCALE;

  logic [SCALE_W-1:0] sc_eff;
  logic [PRE_W:0]     span, lim_full;
  logic [PRE_W-1:0]   pre_q;

  assign sc_eff   = (scale_i > SCALE_W'(MAX_SCALE)) ? SCALE_W'(MAX_SCALE) : scale_i;
  assign span     = (PRE_W+1)'(1) << sc_eff;
  assign lim_full = span - (PRE_W+1)'(1);
  assign step_o   = run_i & ref_tick_i & (pre_q == lim_full[PRE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (!run_i)     pre_q <= '0;
    else if (ref_tick_i) pre_q <= step_o ? '0 : pre_q + PRE_W'(1);
  end

  a_r4_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (pre_q == '0));
  a_r4_idle_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/evt_timer_cmp.sv
module evt_timer_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arrive_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       mode_i,
  input  logic             clr_i,
  input  logic             irq_en_i,
  output logic             flag_o,
  output logic             irq_o
);
  import evt_timer_pkg::*;

  logic hit, flag_q;

  assign hit    = arrive_i & (cnt_nxt_i == cmp_i) & (mode_i == EVT_ON);
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;  // clear beats a same-cycle match
    else if (hit)   flag_q <= 1'b1;
  end

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  a_r6_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrive_i && cnt_nxt_i == cmp_i && mode_i == EVT_ON && !clr_i) |=> flag_o);
  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !(arrive_i && mode_i == EVT_ON)) |=> !flag_o);
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W     = 16,
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [1:0]       irq_en_i,
  output logic [1:0]       irq_o
);
  import evt_timer_pkg::*;

  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [N_CMP-1:0][1:0]       mode_q;
  logic [N_CMP-1:0]            flag;
  logic [CNT_W-1:0]            cnt_q, cnt_nxt, setup_rd;
  logic [SCALE_W-1:0]          scale_q;
  logic                        run_q, claim_q, step;
  logic                        wr_setup, wr_cnt;

  assign wr_setup = wr_en_i & (reg_addr_e'(addr_i) == ADDR_SETUP);
  assign wr_cnt   = wr_en_i & (reg_addr_e'(addr_i) == ADDR_CNT);
  assign cnt_nxt  = cnt_q + CNT_W'(1);

  evt_timer_prescale #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) u_pre (
    .clk_i, .rst_ni, .run_i(run_q), .ref_tick_i, .scale_i(scale_q), .step_o(step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata_i;
    else if (step)   cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      claim_q <= 1'b0;
      scale_q <= '0;
      mode_q  <= '0;
    end else if (wr_setup) begin
      run_q <= wdata_i[RUN_BIT];
      if (!claim_q) begin
        claim_q <= 1'b1;
        scale_q <= wdata_i[SCALE_LSB +: SCALE_W];
        for (int n = 0; n < N_CMP; n++) mode_q[n] <= wdata_i[MODE_LSB + 2*n +: 2];
      end
    end
  end

  for (genvar n = 0; n < N_CMP; n++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      cmp_q[n] <= '0;
      else if (wr_en_i && addr_i == 2'(n)) cmp_q[n] <= wdata_i;
    end

    evt_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk_i, .rst_ni,
      .arrive_i (step & ~wr_cnt),
      .cnt_nxt_i(cnt_nxt),
      .cmp_i    (cmp_q[n]),
      .mode_i   (mode_q[n]),
      .clr_i    (wr_setup & wdata_i[FLAG_LSB + n]),
      .irq_en_i (irq_en_i[n]),
      .flag_o   (flag[n]),
      .irq_o    (irq_o[n])
    );
  end

  always_comb begin
    setup_rd = '0;
    setup_rd[SCALE_LSB +: SCALE_W] = scale_q;
    for (int n = 0; n < N_CMP; n++) begin
      setup_rd[MODE_LSB + 2*n +: 2] = mode_q[n];
      setup_rd[FLAG_LSB + n]        = flag[n];
    end
    setup_rd[RUN_BIT]   = run_q;
    setup_rd[CLAIM_BIT] = claim_q;
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      ADDR_CMP1: rdata_o = cmp_q[0];
      ADDR_CMP2: rdata_o = cmp_q[1];
      ADDR_CNT:  rdata_o = cnt_q;
      default:   rdata_o = setup_rd;
    endcase
  end

  a_r3_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_cnt) |=> $stable(cnt_q));
  a_r5_claim_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q |=> claim_q);
  a_r5_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_q |=> ($stable(scale_q) && $stable(mode_q)));
  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag & irq_en_i));
endmodule

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = 2'd0, irq_en = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;
  int  n_chk = 0, n_fail = 0;
  bit  ref_all = 1'b1;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  evt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_en_i(irq_en), .irq_o(irq)
  );

  // behavioural reference model
  logic [15:0] m_cmp [2];
  logic [15:0] m_cnt;
  bit          m_run, m_claim;
  int          m_scale, m_pre;
  logic [1:0]  m_mode [2];
  bit          m_flag [2];

  always @(posedge clk or negedge rst_n) begin : model
    int  div;
    bit  adv, load;
    logic [15:0] nxt;
    if (!rst_n) begin
      m_cmp[0] = 0; m_cmp[1] = 0; m_cnt = 0; m_run = 0; m_claim = 0;
      m_scale = 0; m_pre = 0; m_mode[0] = 0; m_mode[1] = 0;
      m_flag[0] = 0; m_flag[1] = 0;
    end else begin
      div  = 1 << ((m_scale > 8) ? 8 : m_scale);
      adv  = 0;
      if (!m_run) m_pre = 0;
      else if (ref_tick) begin
        m_pre++;
        if (m_pre == div) begin adv = 1; m_pre = 0; end
      end
      load = wr_en && addr == 2'd2;
      nxt  = m_cnt + 16'd1;
      for (int n = 0; n < 2; n++) begin
        if (wr_en && addr == 2'd3 && wdata[13+n]) m_flag[n] = 0;
        else if (adv && !load && nxt == m_cmp[n] && m_mode[n] == 2'b11) m_flag[n] = 1;
      end
      if (load) m_cnt = wdata;
      else if (adv) m_cnt = nxt;
      if (wr_en && addr == 2'd0) m_cmp[0] = wdata;
      if (wr_en && addr == 2'd1) m_cmp[1] = wdata;
      if (wr_en && addr == 2'd3) begin
        m_run = wdata[11];
        if (!m_claim) begin
          m_claim = 1; m_scale = int'(wdata[3:0]);
          m_mode[0] = wdata[7:6]; m_mode[1] = wdata[9:8];
        end
      end
    end
  end

  function automatic logic [15:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_cmp[0];
      2'd1: return m_cmp[1];
      2'd2: return m_cnt;
      default: return {m_claim, m_flag[1], m_flag[0], 1'b0, m_run, 1'b0,
                       m_mode[1], m_mode[0], 2'b00, 4'(m_scale)};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    check(addr == 2'd2 ? "R3 counter" : (addr == 2'd3 ? "R5 setup" : "R2 compare"),
          32'(rdata), 32'(exp_rd(addr)));
    check("R9 irq", 32'(irq), 32'({m_flag[1] & irq_en[1], m_flag[0] & irq_en[0]}));
  end

  always @(posedge clk) begin
    #1 ref_tick <= ref_all ? 1'b1 : ($urandom % 3 == 0);
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [15:0] e);
    addr = a;
    @(negedge clk);
    check(tag, 32'(rdata), 32'(e));
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [15:0] snap;
    @(posedge clk); #1;
    do_reset();
    // R1 reset state
    rd_chk("R1 setup", 2'd3, 16'h0000);
    rd_chk("R1 counter", 2'd2, 16'h0000);
    check("R1 irq", 32'(irq), 32'h0);
    // R2 register map
    wr(2'd0, 16'h0005);
    wr(2'd1, 16'h000F);
    rd_chk("R2 cmp1", 2'd0, 16'h0005);
    rd_chk("R2 cmp2", 2'd1, 16'h000F);
    // scale 0, both modes armed, run
    irq_en = 2'b11;
    wr(2'd3, 16'h0BC0);
    idle(20);
    check("R9 both irq", 32'(irq), 32'h3);
    irq_en = 2'b01; #1;
    check("R9 gated irq", 32'(irq), 32'h1);
    // R8 stop and clear in one write
    wr(2'd3, 16'h6000);
    rd_chk("R8 stop clear", 2'd3, 16'h83C0);
    check("R8 irq low", 32'(irq), 32'h0);
    addr = 2'd2; @(negedge clk); snap = rdata;
    idle(5);
    rd_chk("R3 holds stopped", 2'd2, snap);
    // R5 locked config
    wr(2'd3, 16'h0805);
    rd_chk("R5 only run changes", 2'd3, 16'h8BC0);
    wr(2'd3, 16'h0000);
    // R6 counter write onto compare sets no flag
    wr(2'd2, 16'h0005);
    rd_chk("R6 load no flag", 2'd3, 16'h83C0);
    // R7 wrap then match
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'h0800);
    idle(3);
    wr(2'd3, 16'h0000);
    rd_chk("R7 wrapped count", 2'd2, 16'h0002);
    rd_chk("R7 match after wrap", 2'd3, 16'hA3C0);

    // R6 mode not 3 gives no flag
    do_reset();
    wr(2'd0, 16'h0001);
    wr(2'd3, 16'h0840);
    idle(5);
    rd_chk("R6 mode 1 no flag", 2'd3, 16'h8840);

    // R4 scale 2
    do_reset();
    wr(2'd0, 16'h0003);
    wr(2'd3, 16'h08C2);
    idle(11);
    rd_chk("R4 scale2 count", 2'd2, 16'h0002);
    rd_chk("R4 scale2 match", 2'd3, 16'hA8C2);

    // R4 scale 9 clamps to 8
    do_reset();
    wr(2'd3, 16'h0809);
    idle(255);
    rd_chk("R4 clamp before", 2'd2, 16'h0000);
    rd_chk("R4 clamp after", 2'd2, 16'h0001);

    // random phase against the model
    do_reset();
    ref_all = 1'b0;
    wr(2'd0, 16'h0007);
    wr(2'd1, 16'h0013);
    wr(2'd3, 16'h0BC1);
    for (int i = 0; i < 4000; i++) begin
      irq_en = 2'($urandom);
      if ($urandom % 8 == 0) begin
        logic [1:0]  a;
        logic [15:0] d;
        a = 2'($urandom);
        case (a)
          2'd3:    d = 16'($urandom) | (($urandom % 4 != 0) ? 16'h0800 : 16'h0000);
          2'd2:    d = ($urandom % 2) ? 16'($urandom % 40) : 16'hFFF0 + 16'($urandom % 16);
          default: d = 16'($urandom % 40);
        endcase
        wr(a, d);
      end else begin
        addr = 2'($urandom);
        idle(1);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule